// File: doc/BRIEF.md
# Cross-Domain Scan Chain with Lockup Stages

This block is a scan chain made of several segments of scan flops. Each segment has its own clock and its own active edge, rising or falling, set by a parameter. While scan enable is high, every flop takes the bit held by the element before it, so a pattern entered at the scan input moves one place per shift toward the scan output. While scan enable is low, every flop loads its own functional data input instead. The functional outputs show the state of every flop.

The clocks of neighbouring segments can be badly skewed. If the capture clock lags the launch clock, a bit can race through a boundary in the same shift. To stop this, a lockup stage is placed at each segment boundary where both sides trigger on the same edge. The stage is clocked by the launching segment's clock. It holds the launched bit through that clock's active phase, so the path into the next segment becomes a half-cycle path. Boundaries where the edges differ get a direct wire. A parameter chooses whether each lockup stage is a level-sensitive latch or a flop that triggers on the opposite edge.

Top module: `xdsc_chain`

## Requirements
- R1: While `scan_en` is 1, each flop loads the previous chain element on its segment's active edge. The bit applied to `scan_in` before shift k (k counted from 0) sits in flop N-1-k after N shifts, where N = NUM_SEG*SEG_LEN. Flop 0 is nearest `scan_in`.
- R2: While `scan_en` is 0, flop i loads `func_d[i]` on its active edge. `func_q[i]` always shows flop i.
- R3: `rst` is synchronous and active high. It clears every flop to 0 on that flop's own active edge and takes priority over shift and capture.
- R4: Bit g of `SEG_RISE` sets the active edge of segment g: 1 for rising, 0 for falling. Segment 0 is nearest `scan_in` and owns flops 0 to SEG_LEN-1, and each later segment owns the next SEG_LEN flops.
- R5: A lockup stage sits only at boundaries where both segments share an active edge. A boundary between different edges is a direct wire. No lockup stage adds a shift position, so the scan-in-to-scan-out latency is exactly N shifts.
- R6: A lockup latch is clocked by the launching segment's clock. It is transparent while that clock is low if the launching segment is rising-edge, and while it is high if the launching segment is falling-edge. Its output does not change while it is closed.
- R7: The chain shifts with no dropped and no duplicated bits when each segment's clock lags the previous segment's clock by any amount under half a period.
- R8: With `LOCKUP_AS_FLOP` = 1, each lockup stage is a flop on the launch clock's opposite edge, and the behaviour at the ports is identical to the latch version.
- R9: `scan_out` equals the last flop, `func_q[N-1]`. After a capture it presents the captured bits from flop N-1 down to flop 0, one per shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seg_clk | input | NUM_SEG | Clock of each segment; bit g clocks segment g |
| rst | input | 1 | Synchronous active-high clear, sampled on each flop's own edge |
| scan_en | input | 1 | 1 = shift along the chain, 0 = capture functional data |
| scan_in | input | 1 | Serial input to flop 0 |
| func_d | input | NUM_SEG*SEG_LEN | Functional data input, one bit per flop |
| func_q | output | NUM_SEG*SEG_LEN | State of every flop |
| scan_out | output | 1 | Serial output from the last flop |

## Verification
On every active edge, the assertions check each flop's own step: the flop follows its scan predecessor while shifting, loads its functional bit while capturing, and clears under reset. They also check that every lockup latch holds its output steady for the whole of its closed phase. These checks cannot show properties of the whole chain. The bench scenarios show them, running with skewed clocks: the exact N-shift latency, that no bit is lost or duplicated across boundaries, that the stage polarity at each boundary is correct, and that the flop-based lockup variant matches the latch variant bit for bit.

// File: rtl/xdsc_pkg.sv
`timescale 1ns/1ps
package xdsc_pkg;

    // Kind of element placed at a segment boundary
    typedef enum logic [1:0] {
        LK_WIRE      = 2'd0,  // edges differ: direct connection
        LK_OPEN_LOW  = 2'd1,  // rising-edge launcher: transparent while clock low
        LK_OPEN_HIGH = 2'd2   // falling-edge launcher: transparent while clock high
    } lockup_kind_e;

    // Per-flop input bundle
    typedef struct packed {
        logic shift_en;
        logic shift_d;
        logic func_d;
    } cell_in_t;

    // Boundary element chosen from the launching and capturing edges
    function automatic lockup_kind_e boundary_kind(input logic launch_rise,
                                                   input logic capture_rise);
        if (launch_rise != capture_rise)
            return LK_WIRE;
        return launch_rise ? LK_OPEN_LOW : LK_OPEN_HIGH;
    endfunction

endpackage

// File: rtl/xdsc_scan_cell.sv
`timescale 1ns/1ps
module xdsc_scan_cell #(
    parameter logic RISE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  xdsc_pkg::cell_in_t cin,
    output logic              q
);
    logic nxt;
    logic act_clk;

    always_comb nxt = cin.shift_en ? cin.shift_d : cin.func_d;

    generate
        if (RISE) begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= nxt;
            end
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= nxt;
            end
        end
    endgenerate

    // Clock seen by the checks: the cell's own active edge is a rising edge here
    assign act_clk = RISE ? clk : ~clk;

    assert_shift_follow_R1: assert property (@(posedge act_clk) disable iff (rst)
        cin.shift_en |=> (q == $past(cin.shift_d)));

    assert_capture_load_R2: assert property (@(posedge act_clk) disable iff (rst)
        !cin.shift_en |=> (q == $past(cin.func_d)));

    assert_reset_clear_R3: assert property (@(posedge act_clk)
        rst |=> (q == 1'b0));

endmodule

// File: rtl/xdsc_segment.sv
`timescale 1ns/1ps
module xdsc_segment #(
    parameter int   LEN  = 4,
    parameter logic RISE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           scan_en,
    input  logic           seg_si,
    input  logic [LEN-1:0] fd,
    output logic [LEN-1:0] q,
    output logic           seg_so
);
    logic [LEN-1:0] prev;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_cell
            xdsc_pkg::cell_in_t cin;

            if (i == 0) begin : g_head
                assign prev[i] = seg_si;
            end else begin : g_body
                assign prev[i] = q[i-1];
            end

            assign cin.shift_en = scan_en;
            assign cin.shift_d  = prev[i];
            assign cin.func_d   = fd[i];

            xdsc_scan_cell #(.RISE(RISE)) u_cell (
                .clk (clk),
                .rst (rst),
                .cin (cin),
                .q   (q[i])
            );
        end
    endgenerate

    assign seg_so = q[LEN-1];

endmodule

// File: rtl/xdsc_lockup.sv
`timescale 1ns/1ps
module xdsc_lockup #(
    parameter xdsc_pkg::lockup_kind_e KIND    = xdsc_pkg::LK_OPEN_LOW,
    parameter logic                   AS_FLOP = 1'b0
) (
    input  logic launch_clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic closed_val;

    generate
        if (AS_FLOP) begin : g_flop
            // Opposite-edge flop: samples half a period after the launch edge
            if (KIND == xdsc_pkg::LK_OPEN_HIGH) begin : g_pos
                always_ff @(posedge launch_clk) q <= d;
            end else begin : g_neg
                always_ff @(negedge launch_clk) q <= d;
            end
        end else begin : g_latch
            if (KIND == xdsc_pkg::LK_OPEN_HIGH) begin : g_high
                always_latch begin
                    if (launch_clk) q = d;
                end
            end else begin : g_low
                always_latch begin
                    if (!launch_clk) q = d;
                end
            end
        end
    endgenerate

    // Latch output must not move between the closing and the opening edge
    generate
        if (!AS_FLOP && KIND == xdsc_pkg::LK_OPEN_HIGH) begin : g_chk_high
            always_ff @(negedge launch_clk) closed_val <= q;
            assert_closed_hold_R6: assert property (@(posedge launch_clk) disable iff (rst)
                q == closed_val);
        end else if (!AS_FLOP) begin : g_chk_low
            always_ff @(posedge launch_clk) closed_val <= q;
            assert_closed_hold_R6: assert property (@(negedge launch_clk) disable iff (rst)
                q == closed_val);
        end else begin : g_chk_none
            assign closed_val = q;
            assert_flop_follow_R8: assert property (
                @(posedge (KIND == xdsc_pkg::LK_OPEN_HIGH ? launch_clk : ~launch_clk))
                disable iff (rst) 1'b1 |=> (q == $past(d)));
        end
    endgenerate

endmodule

// File: rtl/xdsc_chain.sv
`timescale 1ns/1ps
module xdsc_chain #(
    parameter int                NUM_SEG        = 4,
    parameter int                SEG_LEN        = 4,
    parameter logic [NUM_SEG-1:0] SEG_RISE      = 4'b1100,
    parameter logic              LOCKUP_AS_FLOP = 1'b0,
    localparam int               CHAIN_LEN      = NUM_SEG * SEG_LEN
) (
    input  logic [NUM_SEG-1:0]   seg_clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] func_d,
    output logic [CHAIN_LEN-1:0] func_q,
    output logic                 scan_out
);
    logic [NUM_SEG-1:0] seg_head;
    logic [NUM_SEG-1:0] seg_tail;

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
            localparam logic RISE_G = SEG_RISE[g];

            if (g == 0) begin : g_first
                assign seg_head[g] = scan_in;
            end else begin : g_bound
                localparam xdsc_pkg::lockup_kind_e KIND_G =
                    xdsc_pkg::boundary_kind(SEG_RISE[g-1], SEG_RISE[g]);

                if (KIND_G == xdsc_pkg::LK_WIRE) begin : g_wire
                    assign seg_head[g] = seg_tail[g-1];
                end else begin : g_stage
                    xdsc_lockup #(
                        .KIND    (KIND_G),
                        .AS_FLOP (LOCKUP_AS_FLOP)
                    ) u_lockup (
                        .launch_clk (seg_clk[g-1]),
                        .rst        (rst),
                        .d          (seg_tail[g-1]),
                        .q          (seg_head[g])
                    );
                end
            end

            xdsc_segment #(
                .LEN  (SEG_LEN),
                .RISE (RISE_G)
            ) u_segment (
                .clk     (seg_clk[g]),
                .rst     (rst),
                .scan_en (scan_en),
                .seg_si  (seg_head[g]),
                .fd      (func_d[g*SEG_LEN +: SEG_LEN]),
                .q       (func_q[g*SEG_LEN +: SEG_LEN]),
                .seg_so  (seg_tail[g])
            );
        end
    endgenerate

    assign scan_out = seg_tail[NUM_SEG-1];

endmodule

// File: tb/sim_xdsc_chain.sv
`timescale 1ns/1ps
module sim_xdsc_chain;
    localparam int NSEG = 4;
    localparam int SLEN = 4;
    localparam int N    = NSEG * SLEN;

    logic base_clk = 1'b0;
    logic c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic [NSEG-1:0] seg_clk;
    logic rst = 1'b1, scan_en = 1'b0, scan_in = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] q0, q1;
    logic so0, so1;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // 200 MHz; each segment lags the previous by 1 ns (< half period) - R7
    always #2.5 base_clk = ~base_clk;
    always @(base_clk) c1 <= #1.0 base_clk;
    always @(base_clk) c2 <= #2.0 base_clk;
    always @(base_clk) c3 <= #3.0 base_clk;
    assign seg_clk = {c3, c2, c1, base_clk};

    // Segments 0,1 falling (latch open high between them), 2,3 rising
    // (latch open low between them), falling-to-rising boundary is a wire
    xdsc_chain #(.NUM_SEG(NSEG), .SEG_LEN(SLEN), .SEG_RISE(4'b1100), .LOCKUP_AS_FLOP(1'b0)) u0 (
        .seg_clk(seg_clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(q0), .scan_out(so0));

    xdsc_chain #(.NUM_SEG(NSEG), .SEG_LEN(SLEN), .SEG_RISE(4'b1100), .LOCKUP_AS_FLOP(1'b1)) u1 (
        .seg_clk(seg_clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(q1), .scan_out(so1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One shift step: all four segment edges fall in [T+2, T+3.5]; inputs change at T+4.2
    task automatic step();
        @(posedge base_clk);
        #4.2;
    endtask

    // Shift in pattern p so that flop j ends holding p[j]; checks old contents leaving at scan_out
    task automatic shift_pattern(input logic [N-1:0] p, input logic [N-1:0] old);
        scan_en = 1'b1;
        for (int k = 0; k < N; k++) begin
            scan_in = p[N-1-k];
            step();
            if (k < N-1) begin
                check("R1 latch scan_out", {31'b0, so0}, {31'b0, old[N-2-k]});
                check("R8 flop scan_out",  {31'b0, so1}, {31'b0, old[N-2-k]});
            end
        end
        check("R1 R5 R7 latch chain contents", q0, p);
        check("R8 flop chain contents", q1, p);
        check("R9 scan_out is last flop", {31'b0, so0}, {31'b0, p[N-1]});
    endtask

    logic [N-1:0] prev_pat;
    logic [N-1:0] pat;

    initial begin
        repeat (4) step();
        check("R3 reset state latch", q0, '0);
        check("R3 reset state flop", q1, '0);
        rst = 1'b0;
        prev_pat = '0;

        // Walking ones and walking zeros through every position - R1, R4, R5, R7
        for (int b = 0; b < N; b++) begin
            pat = N'(1) << b;
            shift_pattern(pat, prev_pat);
            prev_pat = pat;
        end
        for (int b = 0; b < N; b++) begin
            pat = ~(N'(1) << b);
            shift_pattern(pat, prev_pat);
            prev_pat = pat;
        end
        // Dense and arithmetic patterns
        for (int m = 0; m < 12; m++) begin
            pat = N'((m * 40503 + 4660) ^ (m << 9));
            shift_pattern(pat, prev_pat);
            prev_pat = pat;
        end
        shift_pattern(16'hAAAA, prev_pat);
        shift_pattern(16'h5555, 16'hAAAA);
        prev_pat = 16'h5555;

        // Capture then unload - R2, R9
        for (int m = 0; m < 6; m++) begin
            pat = N'(m * 12345 + 777);
            func_d = pat;
            scan_en = 1'b0;
            step();
            check("R2 capture latch", q0, pat);
            check("R2 capture flop", q1, pat);
            func_d = ~pat;  // must be ignored while shifting
            scan_en = 1'b1;
            scan_in = 1'b0;
            for (int k = 0; k < N; k++) begin
                check("R9 unload latch", {31'b0, so0}, {31'b0, pat[N-1-k]});
                check("R9 unload flop",  {31'b0, so1}, {31'b0, pat[N-1-k]});
                step();
            end
            check("R1 chain emptied latch", q0, '0);
            prev_pat = '0;
        end

        // Reset beats shift and capture - R3
        shift_pattern(16'hFFFF, prev_pat);
        rst = 1'b1;
        scan_in = 1'b1;
        step();
        check("R3 reset during shift latch", q0, '0);
        check("R3 reset during shift flop", q1, '0);
        scan_en = 1'b0;
        func_d = 16'hFFFF;
        step();
        check("R3 reset during capture latch", q0, '0);
        rst = 1'b0;
        step();
        check("R2 capture after reset", q0, 16'hFFFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule